// File: doc/BRIEF.md
# Password-Guarded Watchdog Timer

A watchdog timer seen by software as two 32-bit registers: a control word at offset 0x0 and a live count at offset 0x8. The control word is locked. A new configuration is accepted only when a write to offset 0x0 whose bits 23:16 hold 0xBE is followed directly by a second write to offset 0x0 whose bits 23:16 hold 0xDC. That second write supplies the whole configuration: the run enable, the warning threshold choice, the clock divider choice and a 16-bit reload value.

Once enabled, a prescaler divides the clock by a selectable power of two, and each prescaler tick decrements a 16-bit counter. When the count falls to the selected fraction of the full range, a sticky warning output rises. When the count reaches zero, a reset request is pulsed for one cycle and the counter stops there. Software services the watchdog by repeating the two-write sequence with the enable bit set. This reloads the counter and clears the warning. Repeating the sequence with the enable bit clear stops the timer.

Top module: `pwd_wdog`

## Requirements
- R1: After reset the timer is disabled, both offsets read 0, and warn_o and rst_req_o are low.
- R2: The configuration and the count change only on a committed second write. A 0xBE write followed by any control write whose bits 23:16 are not 0xDC leaves the configuration at offset 0x0 unchanged.
- R3: A control write (offset 0x0) with 0xBE in bits 23:16 arms the unlock. The next control write commits only if it carries 0xDC there. Any other control write disarms, including a 0xDC write that is not armed. Writes to other offsets neither arm nor disarm.
- R4: A committed write takes the enable from bit 31, the warning select from bits 27:26, the divider select from bits 25:24 and the reload from bits 15:0. Offset 0x0 reads these back at the same positions, with all other bits 0.
- R5: Offset 0x8 returns the count in bits 15:0 with bits 31:16 zero. Any offset other than 0x0 and 0x8 reads 0.
- R6: With divider select s, an enabled count above zero decrements once every 2^(6*s) cycles: every cycle for 0, every 64 cycles for 1, every 4096 for 2 and every 0x40000 for 3. The first decrement happens on the 2^(6*s)-th edge after the commit edge.
- R7: Every commit loads the counter with the reload value, restarts the prescaler and clears the warning and the expiry record. A commit wins over a decrement due on the same edge.
- R8: A commit with bit 31 clear stops the counter. The count holds the loaded value, and neither warn_o nor rst_req_o rises.
- R9: The threshold is 0xFFFF >> (w+1) for warning select w, so select 3 gives 0x0FFF, about 1/16 of the full range. warn_o rises on the edge after the first enabled cycle in which the count is at or below the threshold. It stays high until the next commit.
- R10: rst_req_o is high for exactly one cycle: the first enabled cycle in which the count is 0, including the cycle right after a commit that loads 0. The count then stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| warn_o | output | 1 | Sticky pre-warning |
| rst_req_o | output | 1 | One-cycle reset request on expiry |

## Verification
Two functions can fall on the same edge: a service commit and a prescaler decrement, which may be the decrement that would expire the timer. The bench waits with divide-by-one until the count is 2. It then issues the arming write, which lands on the edge that takes the count to 1, and the committing write, which lands on the edge that would take it to 0. The outcome is judged by the count reading the new reload value, by no reset request appearing, and by the warning being cleared and then re-evaluated against the new count. Every cycle is compared with an arithmetic model of the unlock, the prescaler and the counter.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CNT_W    = 16;
  localparam int SEL_W    = 2;
  localparam int CTRL_OFS = 'h0;
  localparam int STAT_OFS = 'h8;
  localparam logic [7:0] PW_ARM = 8'hBE;
  localparam logic [7:0] PW_GO  = 8'hDC;
  localparam int EN_BIT  = 31;
  localparam int WSEL_LSB = 26;
  localparam int DSEL_LSB = 24;
  localparam int PW_LSB  = 16;

  typedef struct packed {
    logic             en;
    logic [SEL_W-1:0] wsel;
    logic [SEL_W-1:0] dsel;
    logic [CNT_W-1:0] reload;
  } wdog_cfg_t;
endpackage

// File: rtl/wdog_unlock.sv
module wdog_unlock
  import wdog_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    pw_i,
  output logic          commit_o
);
  logic ctrl_wr, armed_q;

  assign ctrl_wr  = wr_i && (addr_i == AW'(CTRL_OFS));
  assign commit_o = ctrl_wr && armed_q && (pw_i == PW_GO);

  // any control write re-decides arming; other offsets leave it alone
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      armed_q <= 1'b0;
    else if (ctrl_wr) armed_q <= (pw_i == PW_ARM);
  end
endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale
  import wdog_pkg::*;
#(
  parameter int STEP_LOG2 = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int NSEL  = 1 << SEL_W;
  localparam int PRE_W = (STEP_LOG2 * (NSEL - 1) > 0) ? STEP_LOG2 * (NSEL - 1) : 1;
  localparam logic [PRE_W:0] ONE = 1;

  logic [PRE_W-1:0] lim_tab [NSEL];
  logic [PRE_W-1:0] pre_q;

  for (genvar i = 0; i < NSEL; i++) begin : g_lim
    assign lim_tab[i] = PRE_W'((ONE << (i * STEP_LOG2)) - ONE);
  end

  assign tick_o = run_i && (pre_q == lim_tab[sel_i]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (clr_i)  pre_q <= '0;
    else if (run_i)  pre_q <= tick_o ? '0 : pre_q + 1'b1;
  end
endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             commit_i,
  input  logic             en_i,
  input  logic [SEL_W-1:0] wsel_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             warn_o,
  output logic             req_o
);
  localparam int NSEL = 1 << SEL_W;

  logic [CNT_W-1:0] thr_tab [NSEL];
  logic [CNT_W-1:0] cnt_q;
  logic             warn_q, fired_q;

  for (genvar i = 0; i < NSEL; i++) begin : g_thr
    assign thr_tab[i] = {CNT_W{1'b1}} >> (i + 1);
  end

  assign req_o  = en_i && (cnt_q == '0) && !fired_q;
  assign cnt_o  = cnt_q;
  assign warn_o = warn_q;

  // commit has priority over a decrement due on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      warn_q  <= 1'b0;
      fired_q <= 1'b0;
    end else if (commit_i) begin
      cnt_q   <= reload_i;
      warn_q  <= 1'b0;
      fired_q <= 1'b0;
    end else begin
      if (req_o) fired_q <= 1'b1;
      if (en_i && (cnt_q <= thr_tab[wsel_i])) warn_q <= 1'b1;
      if (tick_i) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/pwd_wdog.sv
module pwd_wdog
  import wdog_pkg::*;
#(
  parameter int AW        = 4,
  parameter int STEP_LOG2 = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  output logic          warn_o,
  output logic          rst_req_o
);
  wdog_cfg_t        cfg_q;
  logic             commit, tick, run;
  logic [CNT_W-1:0] cnt;

  wdog_unlock #(.AW(AW)) u_unlock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_i),
    .addr_i   (addr_i),
    .pw_i     (wdata_i[PW_LSB +: 8]),
    .commit_o (commit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else if (commit) begin
      cfg_q.en     <= wdata_i[EN_BIT];
      cfg_q.wsel   <= wdata_i[WSEL_LSB +: SEL_W];
      cfg_q.dsel   <= wdata_i[DSEL_LSB +: SEL_W];
      cfg_q.reload <= wdata_i[CNT_W-1:0];
    end
  end

  assign run = cfg_q.en && (cnt != '0);

  wdog_prescale #(.STEP_LOG2(STEP_LOG2)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (commit),
    .run_i  (run),
    .sel_i  (cfg_q.dsel),
    .tick_o (tick)
  );

  wdog_count u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (commit),
    .en_i     (cfg_q.en),
    .wsel_i   (cfg_q.wsel),
    .reload_i (wdata_i[CNT_W-1:0]),
    .tick_i   (tick),
    .cnt_o    (cnt),
    .warn_o   (warn_o),
    .req_o    (rst_req_o)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(CTRL_OFS)) begin
      rdata_o[EN_BIT]               = cfg_q.en;
      rdata_o[WSEL_LSB +: SEL_W]    = cfg_q.wsel;
      rdata_o[DSEL_LSB +: SEL_W]    = cfg_q.dsel;
      rdata_o[CNT_W-1:0]            = cfg_q.reload;
    end else if (addr_i == AW'(STAT_OFS)) begin
      rdata_o[CNT_W-1:0]            = cnt;
    end
  end
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk
  import wdog_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             commit_i,
  input wdog_cfg_t        cfg_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             warn_i,
  input logic             req_i,
  input logic [31:0]      wdata_i
);
  p_cfg_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(cfg_i));

  p_cnt_no_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> cnt_i <= $past(cnt_i));

  p_commit_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> (cnt_i == $past(wdata_i[CNT_W-1:0])) && !warn_i);

  p_off_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_i.en && !commit_i) |=> $stable(cnt_i) && !req_i);

  p_warn_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warn_i && !commit_i) |=> warn_i);

  p_req_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> !req_i);

  p_req_at_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> (cnt_i == '0) && cfg_i.en);
endmodule

bind pwd_wdog wdog_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .commit_i (commit),
  .cfg_i    (cfg_q),
  .cnt_i    (cnt),
  .warn_i   (warn_o),
  .req_i    (rst_req_o),
  .wdata_i  (wdata_i)
);

// File: tb/pwd_wdog_tb_top.sv
`timescale 1ns/1ps
module pwd_wdog_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0;
  logic [3:0]  addr_i = 4'h0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        warn_o, rst_req_o;

  int n_chk = 0;
  int n_bad = 0;

  // model state
  logic        m_arm, m_en, m_warn, m_fired;
  logic [1:0]  m_wsel, m_dsel;
  logic [15:0] m_rel, m_cnt;
  int          m_pre;

  always #10 clk_i = ~clk_i;

  pwd_wdog dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .warn_o(warn_o), .rst_req_o(rst_req_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] ctrl_word(input bit en, input logic [1:0] ws,
                                            input logic [1:0] ds, input logic [7:0] pw,
                                            input logic [15:0] rel);
    return {en, 3'b000, ws, ds, pw, rel};
  endfunction

  function automatic logic [31:0] m_ctrl();
    return {m_en, 3'b000, m_wsel, m_dsel, 8'h00, m_rel};
  endfunction

  // one clock: drive, check pre-edge outputs against model, advance model
  task automatic cyc(input bit w, input logic [3:0] a, input logic [31:0] d);
    logic [15:0] thr;
    int          div;
    bit          exp_req, commit;
    wr_i = w; addr_i = a; wdata_i = d;
    #1;
    exp_req = m_en && (m_cnt == 0) && !m_fired;
    chk(rst_req_o == exp_req, "R10 req", {31'b0, rst_req_o}, {31'b0, exp_req});
    chk(warn_o == m_warn, "R9 warn", {31'b0, warn_o}, {31'b0, m_warn});
    if (!w) begin
      if (a == 4'h8)      chk(rdata_o == {16'h0, m_cnt}, "R6 count", rdata_o, {16'h0, m_cnt});
      else if (a == 4'h0) chk(rdata_o == m_ctrl(), "R4 ctrl", rdata_o, m_ctrl());
      else                chk(rdata_o == 32'h0, "R5 other", rdata_o, 32'h0);
    end
    thr = 16'hFFFF >> (m_wsel + 1);
    div = 1 << (6 * m_dsel);
    commit = w && (a == 4'h0) && m_arm && (d[23:16] == 8'hDC);
    if (w && a == 4'h0) m_arm = (d[23:16] == 8'hBE);
    if (commit) begin
      m_en = d[31]; m_wsel = d[27:26]; m_dsel = d[25:24]; m_rel = d[15:0];
      m_cnt = d[15:0]; m_pre = 0; m_warn = 1'b0; m_fired = 1'b0;
    end else begin
      if (exp_req) m_fired = 1'b1;
      if (m_en && m_cnt <= thr) m_warn = 1'b1;
      if (m_en && m_cnt != 0) begin
        if (m_pre == div - 1) begin m_pre = 0; m_cnt = m_cnt - 1'b1; end
        else m_pre = m_pre + 1;
      end
    end
    @(negedge clk_i);
  endtask

  task automatic idle(input int n, input logic [3:0] a);
    for (int i = 0; i < n; i++) cyc(1'b0, a, 32'h0);
  endtask

  task automatic unlock(input bit en, input logic [1:0] ws, input logic [1:0] ds, input logic [15:0] rel);
    cyc(1'b1, 4'h0, ctrl_word(1'b0, 2'b0, 2'b0, 8'hBE, 16'h0));
    cyc(1'b1, 4'h0, ctrl_word(en, ws, ds, 8'hDC, rel));
  endtask

  task automatic peek(input logic [3:0] a, input logic [31:0] exp, input string tag);
    wr_i = 1'b0; addr_i = a; #1;
    chk(rdata_o == exp, tag, rdata_o, exp);
  endtask

  initial begin
    #4000000;
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    m_arm = 0; m_en = 0; m_warn = 0; m_fired = 0; m_wsel = 0; m_dsel = 0;
    m_rel = 0; m_cnt = 0; m_pre = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    peek(4'h0, 32'h0, "R1 ctrl");
    peek(4'h8, 32'h0, "R1 status");
    chk(!warn_o && !rst_req_o, "R1 outputs", {30'b0, warn_o, rst_req_o}, 32'h0);
    idle(3, 4'h4);

    // R3 lone 0xDC write, and BE / wrong / DC, must not commit
    cyc(1'b1, 4'h0, ctrl_word(1'b1, 2'd3, 2'd0, 8'hDC, 16'd5));
    idle(2, 4'h8);
    peek(4'h8, 32'h0, "R3 unarmed DC ignored");
    cyc(1'b1, 4'h0, ctrl_word(1'b0, 2'd0, 2'd0, 8'hBE, 16'h0));
    cyc(1'b1, 4'h0, ctrl_word(1'b1, 2'd1, 2'd1, 8'h12, 16'd9));
    cyc(1'b1, 4'h0, ctrl_word(1'b1, 2'd3, 2'd0, 8'hDC, 16'd7));
    idle(2, 4'h0);
    peek(4'h0, 32'h0, "R3 disarmed by wrong password");

    // R3 write to another offset keeps arming
    cyc(1'b1, 4'h0, ctrl_word(1'b0, 2'd0, 2'd0, 8'hBE, 16'h0));
    cyc(1'b1, 4'h8, ctrl_word(1'b0, 2'd0, 2'd0, 8'h55, 16'h0));
    cyc(1'b1, 4'h0, ctrl_word(1'b1, 2'd3, 2'd0, 8'hDC, 16'd40));
    peek(4'h0, ctrl_word(1'b1, 2'd3, 2'd0, 8'h00, 16'd40), "R3 arm kept across other offset");

    // R2 armed then non-DC control write leaves config
    cyc(1'b1, 4'h0, ctrl_word(1'b0, 2'd0, 2'd0, 8'hBE, 16'h0));
    cyc(1'b1, 4'h0, ctrl_word(1'b0, 2'd1, 2'd2, 8'hBE, 16'd3));
    peek(4'h0, ctrl_word(1'b1, 2'd3, 2'd0, 8'h00, 16'd40), "R2 config held");
    idle(2, 4'h4);

    // R4 R6 R9 R10 reload sweep, divide by one
    for (int r = 0; r <= 12; r++) begin
      unlock(1'b1, 2'd3, 2'd0, 16'(r));
      idle(1, 4'h0);
      idle(r + 4, 4'h8);
    end

    // R6 larger dividers
    unlock(1'b1, 2'd3, 2'd1, 16'd3);
    idle(3 * 64 + 6, 4'h8);
    unlock(1'b1, 2'd2, 2'd2, 16'd2);
    idle(2 * 4096 + 6, 4'h8);
    unlock(1'b1, 2'd0, 2'd3, 16'd1);
    idle(60, 4'h8);

    // R9 threshold per select, counting across the boundary
    for (int w = 0; w < 4; w++) begin
      unlock(1'b1, 2'(w), 2'd0, 16'((16'hFFFF >> (w + 1)) + 3));
      idle(8, 4'h8);
    end

    // R7 service lands on the edge that would expire the count
    unlock(1'b1, 2'd3, 2'd0, 16'd5);
    while (m_cnt != 16'd2) cyc(1'b0, 4'h8, 32'h0);
    unlock(1'b1, 2'd0, 2'd0, 16'h9000);
    peek(4'h8, 32'h9000, "R7 commit beats expiring decrement");
    chk(!rst_req_o, "R7 no request", {31'b0, rst_req_o}, 32'h0);
    idle(6, 4'h8);

    // R8 disable holds count
    unlock(1'b0, 2'd3, 2'd0, 16'd9);
    idle(20, 4'h8);
    peek(4'h8, 32'd9, "R8 count held when off");
    chk(!warn_o && !rst_req_o, "R8 quiet when off", {30'b0, warn_o, rst_req_o}, 32'h0);
    unlock(1'b0, 2'd3, 2'd0, 16'd0);
    idle(5, 4'h8);
    idle(2, 4'hC);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule